// File: doc/BRIEF.md
# Banked Cartridge ROM Address Controller

This block sits between a 16-bit CPU bus and a cartridge ROM. Writes aimed at the ROM address space do not reach the storage. They load two control registers instead. The first is an enable flag for the external-RAM window. The second is a 7-bit bank selector for the switchable ROM window.

Reads in the lower 16 KB window always come from bank 0. Reads in the upper 16 KB window come from the selected bank, taken modulo the number of banks present. The controller turns each read address into a flat ROM byte address. It reads the synchronous ROM array and returns the byte one cycle after the read strobe. Any address that holds no ROM returns 0xFF.

The ROM array is parameterised by bank count and by the number of bytes populated in each bank. A testbench can preload it by hierarchical assignment. The block only reports whether the RAM window is enabled. Nothing is attached behind that window.

Top module: `cart_rom_ctrl`

## Requirements
- R1: A write (wr_i=1) to any address in 0x0000–0x1FFF sets the enable flag when wdata_i[3:0] equals 4'hA, and clears it for any other value; the new value is visible from the next cycle.
- R2: A write to any address in 0x2000–0x3FFF loads the bank register with wdata_i[6:0]; bit 7 is ignored, and a value of 0 selects bank 0 with no substitution.
- R3: After reset the bank register is 1, the enable flag is 0 and rd_data_o is 0xFF.
- R4: A read address in 0x0000–0x3FFF maps to bank 0 at the same offset: rom_addr_o equals the address.
- R5: A read address in 0x4000–0x7FFF maps to rom_addr_o = eff*0x4000 + (address − 0x4000), where eff = bank register mod BANK_COUNT.
- R6: A read at any address with bit 15 set (this includes 0xA000–0xBFFF) returns 0xFF.
- R7: Writes to 0x4000–0x7FFF or to any address with bit 15 set change neither the enable flag nor the bank register.
- R8: rd_data_o is registered. It shows the result of a read strobe from the cycle after that strobe, and it holds while rd_i is 0.
- R9: A ROM-range read whose in-bank offset (address bits 13:0) is BANK_BYTES or more returns 0xFF; otherwise it returns the byte stored at index eff_bank*BANK_BYTES + offset.
- R10: ram_en_o is the current value of the enable flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU bus address |
| wdata_i | input | 8 | CPU write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| rom_addr_o | output | 21 | Translated ROM byte address, 0 outside 0x0000–0x7FFF |
| ram_en_o | output | 1 | External-RAM window enable flag |

## Verification
The bench builds the block with BANK_COUNT=5 and BANK_BYTES=64. Because five is not a power of two, selections 5, 7 and 127 really wrap to 0, 2 and 2, which tests the modulo. The small fill size puts offsets at 64 and above within reach, so the bench can check the 0xFF return for bytes past the populated part of a bank. It preloads a distinct byte into every location, derived from bank and offset. This lets it tell a wrong bank apart from a wrong offset.

// File: rtl/cart_rom_pkg.sv
package cart_rom_pkg;
  localparam int unsigned BUS_W    = 16;
  localparam int unsigned SPAN_W   = 14;  // 16 KB bank span
  localparam int unsigned BANK_W   = 7;
  localparam int unsigned ROM_AW   = BANK_W + SPAN_W;
  localparam logic [7:0]  OPEN_BUS = 8'hFF;
  localparam logic [3:0]  EN_KEY   = 4'hA;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_BANK = 2'd1,
    REG_NONE = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_wr(input logic [BUS_W-1:0] a);
    if (a[15:13] == 3'b000)      return REG_EN;
    else if (a[15:13] == 3'b001) return REG_BANK;
    else                         return REG_NONE;
  endfunction
endpackage

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_rom_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [BUS_W-1:0]  addr_i,
  input  logic [7:0]        wdata_i,
  output logic              en_o,
  output logic [BANK_W-1:0] bank_o
);
  reg_sel_e sel;
  assign sel = decode_wr(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      bank_o <= BANK_W'(1);
    end else if (wr_i) begin
      unique case (sel)
        REG_EN:   en_o   <= (wdata_i[3:0] == EN_KEY);
        REG_BANK: bank_o <= wdata_i[BANK_W-1:0];
        default:  ;
      endcase
    end
  end

  p_en_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b000) |=> (en_o == ($past(wdata_i[3:0]) == 4'hA)));

  p_bank_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[15:13] == 3'b001) |=> (bank_o == $past(wdata_i[6:0])));

  p_no_side_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (addr_i[15] || addr_i[14])) |=> ($stable(bank_o) && $stable(en_o)));
endmodule

// File: rtl/cart_addr_xlate.sv
module cart_addr_xlate
  import cart_rom_pkg::*;
#(
  parameter int unsigned BANK_COUNT = 128,
  parameter int unsigned BANK_BYTES = 16,
  localparam int unsigned OFF_W     = $clog2(BANK_BYTES),
  localparam int unsigned IDX_W     = $clog2(BANK_COUNT * BANK_BYTES)
) (
  input  logic [BUS_W-1:0]  addr_i,
  input  logic [BANK_W-1:0] bank_i,
  output logic [ROM_AW-1:0] rom_addr_o,
  output logic              is_rom_o,
  output logic              in_fill_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [7:0]        eff8;
  logic [BANK_W-1:0] win_bank;
  logic [SPAN_W-1:0] offset;

  always_comb begin
    eff8       = {1'b0, bank_i} % 8'(BANK_COUNT);
    offset     = addr_i[SPAN_W-1:0];
    is_rom_o   = !addr_i[15];
    win_bank   = addr_i[14] ? eff8[BANK_W-1:0] : '0;
    rom_addr_o = is_rom_o ? {win_bank, offset} : '0;
    in_fill_o  = int'(offset) < int'(BANK_BYTES);
    idx_o      = IDX_W'(int'(win_bank) * int'(BANK_BYTES) + int'(offset[OFF_W-1:0]));
  end
endmodule

// File: rtl/cart_rom_array.sv
module cart_rom_array #(
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] idx_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // Blank fill; bench or loader overwrites
  initial begin
    for (int i = 0; i < int'(DEPTH); i++) mem_q[i] = 8'hFF;
  end

  always_ff @(posedge clk_i) begin
    if (rd_en_i) rdata_o <= mem_q[idx_i];
  end
endmodule

// File: rtl/cart_rom_ctrl.sv
module cart_rom_ctrl
  import cart_rom_pkg::*;
#(
  parameter int unsigned BANK_COUNT = 128,
  parameter int unsigned BANK_BYTES = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [7:0]  rd_data_o,
  output logic [20:0] rom_addr_o,
  output logic        ram_en_o
);
  localparam int unsigned DEPTH = BANK_COUNT * BANK_BYTES;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [BANK_W-1:0] bank;
  logic              is_rom, in_fill, rd_en, hit_q;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        rom_q;

  cart_bank_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .en_o   (ram_en_o),
    .bank_o (bank)
  );

  cart_addr_xlate #(
    .BANK_COUNT(BANK_COUNT),
    .BANK_BYTES(BANK_BYTES)
  ) u_xlate (
    .addr_i    (addr_i),
    .bank_i    (bank),
    .rom_addr_o(rom_addr_o),
    .is_rom_o  (is_rom),
    .in_fill_o (in_fill),
    .idx_o     (idx)
  );

  assign rd_en = rd_i && is_rom && in_fill;

  cart_rom_array #(.DEPTH(DEPTH)) u_rom (
    .clk_i  (clk_i),
    .rd_en_i(rd_en),
    .idx_i  (idx),
    .rdata_o(rom_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hit_q <= 1'b0;
    else if (rd_i) hit_q <= rd_en;
  end

  assign rd_data_o = hit_q ? rom_q : OPEN_BUS;

  p_low_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o == {5'b0, addr_i}));

  p_bank_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b01) |-> (int'(rom_addr_o[20:14]) < int'(BANK_COUNT)));

  p_open_bus_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15]) |=> (rd_data_o == 8'hFF));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rd_data_o));
endmodule

// File: tb/cart_rom_ctrl_tb.sv
module cart_rom_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int BB = 64;
  localparam int NV = 25;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  rd_data;
  logic [20:0] rom_addr;
  logic        ram_en;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_rom_ctrl #(.BANK_COUNT(NB), .BANK_BYTES(BB)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rd_data_o(rd_data), .rom_addr_o(rom_addr),
    .ram_en_o(ram_en)
  );

  // op: 0 write, 1 read and compare, 2 compare enable flag
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 16'h0000, 8'h0A, 8'h00},
    {2'd2, 16'h0000, 8'h00, 8'h01},
    {2'd1, 16'h4010, 8'h00, 8'h78},
    {2'd0, 16'h2000, 8'h03, 8'h00},
    {2'd1, 16'h4005, 8'h00, 8'h8B},
    {2'd0, 16'h2100, 8'h07, 8'h00},
    {2'd1, 16'h4001, 8'h00, 8'h52},
    {2'd0, 16'h3FFF, 8'h85, 8'h00},
    {2'd1, 16'h4002, 8'h00, 8'h0D},
    {2'd0, 16'h2000, 8'h00, 8'h00},
    {2'd1, 16'h4003, 8'h00, 8'h12},
    {2'd1, 16'h0020, 8'h00, 8'hA3},
    {2'd1, 16'hA000, 8'h00, 8'hFF},
    {2'd1, 16'h8000, 8'h00, 8'hFF},
    {2'd1, 16'hC123, 8'h00, 8'hFF},
    {2'd1, 16'h4040, 8'h00, 8'hFF},
    {2'd1, 16'h0040, 8'h00, 8'hFF},
    {2'd0, 16'h2000, 8'h04, 8'h00},
    {2'd1, 16'h403F, 8'h00, 8'hD2},
    {2'd0, 16'h2000, 8'h7F, 8'h00},
    {2'd1, 16'h4000, 8'h00, 8'h4D},
    {2'd0, 16'h1FFF, 8'h5A, 8'h00},
    {2'd2, 16'h0000, 8'h00, 8'h01},
    {2'd0, 16'h0800, 8'hA5, 8'h00},
    {2'd2, 16'h0000, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    #1;
    for (int b = 0; b < NB; b++)
      for (int o = 0; o < BB; o++)
        u_dut.u_rom.mem_q[b*BB + o] = 8'(37*b + 5*o + 3);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3 reset state
    @(negedge clk);
    addr = 16'h4000;
    #1;
    check("R3 rd_data", {24'b0, rd_data}, 32'hFF);
    check("R3 enable", {31'b0, ram_en}, 32'h0);
    check("R3 bank 1", {11'b0, rom_addr}, 32'h4000);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [15:0] a;
      logic [7:0]  d, e;
      string rq;
      {op, a, d, e} = VEC[i];
      if (op == 2'd0) bus_wr(a, d);
      else if (op == 2'd1) begin
        bus_rd(a);
        rq = a[15] ? "R6" : (a[13:0] >= 14'(BB)) ? "R9" : a[14] ? "R5" : "R4";
        check(rq, {24'b0, rd_data}, {24'b0, e});
      end else begin
        #1;
        check("R1 R10 enable", {31'b0, ram_en}, {31'b0, e[0]});
      end
    end

    // R2 bit 7 ignored, zero kept as bank 0
    bus_wr(16'h2000, 8'h80);
    addr = 16'h4123; #1;
    check("R2 bank0 map", {11'b0, rom_addr}, 32'h0123);

    // R7 writes outside register ranges ignored
    bus_wr(16'h4000, 8'h0A);
    bus_wr(16'h6000, 8'h02);
    bus_wr(16'h9000, 8'h03);
    bus_wr(16'hA000, 8'h0A);
    addr = 16'h4001; #1;
    check("R7 bank kept", {11'b0, rom_addr}, 32'h0001);
    check("R7 enable kept", {31'b0, ram_en}, 32'h0);

    // R5 translation at window top and wrap of 127
    bus_wr(16'h2000, 8'h03);
    addr = 16'h7FFF; #1;
    check("R5 top of bank3", {11'b0, rom_addr}, 32'h0FFFF);
    bus_wr(16'h2000, 8'h7F);
    addr = 16'h4000; #1;
    check("R5 127 mod 5", {11'b0, rom_addr}, 32'h08000);
    addr = 16'h9000; #1;
    check("R5 no rom addr outside", {11'b0, rom_addr}, 32'h0);

    // R8 latency and hold
    bus_rd(16'h0001);
    check("R8 first cycle", {24'b0, rd_data}, 32'h08);
    addr = 16'hA000;
    repeat (3) @(negedge clk);
    check("R8 hold", {24'b0, rd_data}, 32'h08);

    finish_run();
  end
endmodule